// File: doc/BRIEF.md
# Strobe-Handshaked Nibble FIFO

This block is a first-in first-out store of sixteen 4-bit words. Its write side and its read side are each driven by a strobe and report through a ready flag, so the two sides can run at unrelated rates. Both strobes come from outside the clock domain. Each strobe passes through a two-flop synchronizer, and an edge detector then turns it into a single-cycle request.

A writer presents a nibble and raises the shift-in strobe while input-ready is high. A reader takes the word shown on the data outputs and then drops the shift-out strobe while output-ready is high. The oldest valid word is always on the data outputs.

Each ready flag goes low for one cycle after an accepted operation. Because of this, two blocks can be chained into a deeper store:
- upstream output-ready drives downstream shift-in;
- downstream input-ready drives upstream shift-out;
- upstream data outputs drive downstream data inputs.

A flush input marks every word invalid and leaves the storage bits untouched. A float input puts the data outputs into high impedance.

Top module: `nibble_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointers and word count are reset. After that edge, `in_rdy` is 1 and `out_rdy` is 0.
- R2: A low-to-high change of `shift_in` stores `din` if `in_rdy` is high when the synchronized edge is detected. Take the strobe as stable before clock edge k. Then the flags show the new word after edge k+2, and not before. `in_rdy` is low for exactly the cycle between edge k+2 and edge k+3.
- R3: A high-to-low change of `shift_out` removes the word on `dout` if `out_rdy` is high at detection. The removal follows the same three-edge latency as a write. `dout` then shows the next oldest word. `out_rdy` is low for exactly one cycle after each removal.
- R4: Words leave in the order they arrived. `in_rdy` stays low once 16 valid words are held.
- R5: A shift-in edge while the store is full is ignored. The word count and the later read-out order are unchanged.
- R6: A shift-out edge while the store is empty is ignored, and `out_rdy` stays 0.
- R7: When a shift-in edge and a shift-out edge are detected in the same cycle, the following holds:
  - on a store that is neither empty nor full, both take effect and the count is unchanged;
  - on a full store, only the removal happens;
  - on an empty store, only the write happens.
- R8: While `flush` is high, `in_rdy` is 1 and `out_rdy` is 0, and strobe edges are ignored. When `flush` returns low, the store is empty.
- R9: Flush does not clear storage. It returns both pointers to slot 0, which is the slot of the first word written after reset. After a flush, `dout` shows the stale content of slot 0 until the next write overwrites that slot.
- R10: While `float_q` is 1, `dout` is high impedance. When `float_q` is 0, the head word is driven again unchanged.
- R11: Two instances chained as described above move every word written upstream into the downstream store on their own. The words arrive in the same order, and the upstream store is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Active-high: invalidate all words, force flags |
| shift_in | input | 1 | Write strobe, acts on its rising edge |
| din | input | WIDTH | Nibble to store |
| shift_out | input | 1 | Read strobe, acts on its falling edge |
| float_q | input | 1 | 1 puts `dout` in high impedance |
| in_rdy | output | 1 | High when a write will be accepted |
| out_rdy | output | 1 | High when `dout` holds a valid word |
| dout | output | WIDTH | Oldest valid word |

## Verification
Errors in the write pointer, read pointer or word count each show up at the ports in a different way:
- A wrong pointer puts a word on `dout` that does not match the scoreboard head. This appears on the very read that follows the error.
- A count that drifts makes `in_rdy` or `out_rdy` disagree with the model occupancy. This is seen one settle window after the faulty strobe, or at the full and empty boundaries.
- A missing or misplaced acknowledge pulse stalls the chained pair. It shows up as words that never reach the downstream store.
- A flush that clears storage changes the stale value read from slot 0.

// File: rtl/nfifo_pkg.sv
// Package: shared constants and types for the nibble FIFO.
// Assumes: no other package defines the same names.
package nfifo_pkg;
    localparam int unsigned NF_WIDTH = 4;
    localparam int unsigned NF_DEPTH = 16;
    localparam int unsigned NF_SYNC_STAGES = 2;

    // Edge a strobe detector reacts to.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sense_t;
endpackage

// File: rtl/nfifo_strobe_sync.sv
// Strobe synchronizer: brings an asynchronous strobe into the clock domain
// through STAGES flops, then emits a one-cycle pulse on the selected edge.
// Assumes: strobe levels last several clock periods. The reset value is
// chosen so that no idle level creates a false event right after reset.
module nfifo_strobe_sync
    import nfifo_pkg::*;
#(
    parameter edge_sense_t SENSE  = EDGE_RISE,
    parameter int unsigned STAGES = NF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_raw,
    output logic hit
);
    localparam logic RST_LEVEL = (SENSE == EDGE_RISE);

    logic [STAGES:0] chain;

    // Shift the raw strobe through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {(STAGES + 1){RST_LEVEL}};
        end else begin
            chain <= {chain[STAGES-1:0], strobe_raw};
        end
    end

    // Pick the edge detector variant required by SENSE.
    generate
        if (SENSE == EDGE_RISE) begin : g_rise
            assign hit = chain[STAGES-1] & ~chain[STAGES];
        end else begin : g_fall
            assign hit = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate
endmodule

// File: rtl/nfifo_store.sv
// Circular word store with occupancy count and ready flags.
// Each ready flag drops for one cycle after an accepted operation, so a
// downstream or upstream stage sees a fresh strobe edge per word.
// Assumes: wr_req and rd_req are single-cycle pulses. Flush is
// synchronous. Storage bits are never reset.
module nfifo_store #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_req,
    input  logic                         rd_req,
    input  logic [WIDTH-1:0]             din,
    output logic [WIDTH-1:0]             head,
    output logic                         in_rdy,
    output logic                         out_rdy,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         wr_fire,
    output logic                         rd_fire
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic             wr_ack;
    logic             rd_ack;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Derive flags from the registered count and the acknowledge pulses.
    always_comb begin
        in_rdy  = flush | ((occ != FULL) & ~wr_ack);
        out_rdy = ~flush & (occ != '0) & ~rd_ack;
        wr_fire = wr_req & in_rdy & ~flush;
        rd_fire = rd_req & out_rdy;
        head    = mem[rp];
    end

    // Write the accepted word into its slot; storage has no reset.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wp] <= din;
        end
    end

    // Advance pointers and count; flush invalidates without clearing data.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp     <= '0;
            rp     <= '0;
            occ    <= '0;
            wr_ack <= 1'b0;
            rd_ack <= 1'b0;
        end else begin
            wr_ack <= wr_fire;
            rd_ack <= rd_fire;
            if (wr_fire) begin
                wp <= bump(wp);
            end
            if (rd_fire) begin
                rp <= bump(rp);
            end
            case ({wr_fire, rd_fire})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/nfifo_out_drive.sv
// Output driver: passes the head word to the pins or floats them.
// Assumes: the pins resolve on a net. One driver per bit.
module nfifo_out_drive #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             float_q,
    input  logic [WIDTH-1:0] word,
    output wire  [WIDTH-1:0] pin
);
    // One tri-state driver per data bit.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign pin[i] = float_q ? 1'bz : word[i];
        end
    endgenerate
endmodule

// File: rtl/nibble_fifo.sv
// Top: strobe-handshaked FIFO. It synchronizes the write strobe on its
// rising edge and the read strobe on its falling edge, keeps the words in
// a circular store and drives the head word onto tri-state pins.
// Assumes: strobes are asynchronous to clk and slower than the three-cycle
// detection path.
module nibble_fifo
    import nfifo_pkg::*;
#(
    parameter int unsigned WIDTH = NF_WIDTH,
    parameter int unsigned DEPTH = NF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_out,
    input  logic             float_q,
    output logic             in_rdy,
    output logic             out_rdy,
    output wire  [WIDTH-1:0] dout
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic             wr_req;
    logic             rd_req;
    logic             wr_fire;
    logic             rd_fire;
    logic [CW-1:0]    occ;
    logic [WIDTH-1:0] head;

    nfifo_strobe_sync #(.SENSE(EDGE_RISE), .STAGES(NF_SYNC_STAGES)) u_wr_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_raw (shift_in),
        .hit        (wr_req)
    );

    nfifo_strobe_sync #(.SENSE(EDGE_FALL), .STAGES(NF_SYNC_STAGES)) u_rd_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_raw (shift_out),
        .hit        (rd_req)
    );

    nfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .din     (din),
        .head    (head),
        .in_rdy  (in_rdy),
        .out_rdy (out_rdy),
        .occ     (occ),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    nfifo_out_drive #(.WIDTH(WIDTH)) u_drive (
        .float_q (float_q),
        .word    (head),
        .pin     (dout)
    );
endmodule

// File: rtl/nfifo_chk.sv
// Checker: temporal properties of the FIFO flags and occupancy.
// Assumes: bound into nibble_fifo and fed its internal count and fire pulses.
module nfifo_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       in_rdy,
    input logic                       out_rdy,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       wr_fire,
    input logic                       rd_fire
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ALMOST = CW'(DEPTH - 1);

    // R8
    flush_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (in_rdy && !out_rdy));

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL);

    // R6
    out_rdy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_rdy |-> (occ != '0));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL && !flush) |=> (occ == FULL || occ == ALMOST));

    // R7
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (occ == $past(occ) || occ == $past(occ) + 1'b1 || occ == $past(occ) - 1'b1));

    // R2
    wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (!in_rdy || flush));

    // R3
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> !out_rdy);
endmodule

bind nibble_fifo nfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .in_rdy  (in_rdy),
    .out_rdy (out_rdy),
    .occ     (occ),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
);

// File: tb/test_nibble_fifo.sv
// Scoreboard bench: push tasks queue expected words, pull tasks compare
// the head word against the queue as the design presents it.
module test_nibble_fifo;
    localparam int W = 4;
    localparam int D = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         shift_in = 1'b0;
    logic         shift_out = 1'b1;
    logic         float_q = 1'b0;
    logic [W-1:0] din = '0;
    logic         in_rdy;
    logic         out_rdy;
    wire  [W-1:0] dout;

    nibble_fifo #(.WIDTH(W), .DEPTH(D)) i_nibble_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .shift_in(shift_in),
        .din(din), .shift_out(shift_out), .float_q(float_q),
        .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout)
    );

    // Chained pair for R11.
    logic         c_shin = 1'b0;
    logic [W-1:0] c_din = '0;
    logic         c_shout = 1'b1;
    logic         a_ir, a_or, b_ir, b_or;
    wire  [W-1:0] a_q;
    wire  [W-1:0] b_q;

    nibble_fifo #(.WIDTH(W), .DEPTH(D)) i_head_stage (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .shift_in(c_shin),
        .din(c_din), .shift_out(b_ir), .float_q(1'b0),
        .in_rdy(a_ir), .out_rdy(a_or), .dout(a_q)
    );

    nibble_fifo #(.WIDTH(W), .DEPTH(D)) i_tail_stage (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .shift_in(a_or),
        .din(a_q), .shift_out(c_shout), .float_q(1'b0),
        .in_rdy(b_ir), .out_rdy(b_or), .dout(b_q)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] sb[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flags(input string req);
        chk(in_rdy == (sb.size() < D), {req, " in_rdy"}, int'(in_rdy), int'(sb.size() < D));
        chk(out_rdy == (sb.size() > 0), {req, " out_rdy"}, int'(out_rdy), int'(sb.size() > 0));
    endtask

    // Driver: strobe one word in, queue it if the model says it fits.
    task automatic push(input logic [W-1:0] v);
        bit acc;
        acc = (sb.size() < D);
        din = v;
        shift_in = 1'b1;
        nclk(4);
        shift_in = 1'b0;
        nclk(4);
        if (acc) sb.push_back(v);
    endtask

    // Monitor: compare head with the scoreboard, then strobe it out.
    task automatic pull(input string req);
        if (sb.size() > 0) begin
            chk(dout === sb[0], {req, " head"}, int'(dout), int'(sb[0]));
        end
        shift_out = 1'b0;
        nclk(4);
        shift_out = 1'b1;
        nclk(4);
        if (sb.size() > 0) void'(sb.pop_front());
    endtask

    // Both strobes together; the model applies read then write.
    task automatic both(input logic [W-1:0] v, input string req);
        bit do_wr;
        bit do_rd;
        do_rd = (sb.size() > 0);
        do_wr = (sb.size() < D);
        if (do_rd) chk(dout === sb[0], {req, " head"}, int'(dout), int'(sb[0]));
        din = v;
        shift_in = 1'b1;
        shift_out = 1'b0;
        nclk(4);
        shift_in = 1'b0;
        shift_out = 1'b1;
        nclk(4);
        if (do_rd) void'(sb.pop_front());
        if (do_wr) sb.push_back(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        nclk(4);
        // R1: reset state
        chk(in_rdy == 1'b1, "R1 in_rdy", int'(in_rdy), 1);
        chk(out_rdy == 1'b0, "R1 out_rdy", int'(out_rdy), 0);
        rst_n = 1'b1;
        nclk(2);
        flags("R1");

        // R2: exact latency of a write and the input-ready pulse
        din = 4'hA;
        shift_in = 1'b1;
        nclk(2);
        chk(out_rdy == 1'b0, "R2 early out_rdy", int'(out_rdy), 0);
        nclk(1);
        chk(out_rdy == 1'b1, "R2 out_rdy", int'(out_rdy), 1);
        chk(in_rdy == 1'b0, "R2 ack pulse", int'(in_rdy), 0);
        nclk(1);
        chk(in_rdy == 1'b1, "R2 in_rdy back", int'(in_rdy), 1);
        shift_in = 1'b0;
        nclk(4);
        sb.push_back(4'hA);
        chk(dout === 4'hA, "R2 head", int'(dout), 10);

        // R8 / R9: flush keeps storage, forces flags, ignores strobes
        push(4'h5);
        push(4'hC);
        flush = 1'b1;
        nclk(1);
        chk(in_rdy == 1'b1, "R8 in_rdy", int'(in_rdy), 1);
        chk(out_rdy == 1'b0, "R8 out_rdy", int'(out_rdy), 0);
        din = 4'h7;
        shift_in = 1'b1;
        nclk(4);
        shift_in = 1'b0;
        nclk(4);
        flush = 1'b0;
        nclk(2);
        sb.delete();
        flags("R8");
        chk(dout === 4'hA, "R9 stale slot0", int'(dout), 10);
        push(4'h3);
        chk(dout === 4'h3, "R9 overwrite", int'(dout), 3);
        flags("R9");

        // R6: read on empty ignored
        pull("R3");
        flags("R3");
        pull("R6");
        flags("R6");
        push(4'h6);
        flags("R6");
        pull("R6");
        flags("R6");

        // R4 / R5: fill, overfill, drain in order
        for (int i = 0; i < D; i++) push(4'((i * 7 + 1) & 15));
        flags("R4");
        push(4'h0);
        flags("R5");
        for (int i = 0; i < D; i++) pull("R5");
        flags("R5");

        // R7: simultaneous strobes, middle, full and empty
        push(4'h1);
        push(4'h2);
        push(4'h4);
        both(4'h8, "R7");
        both(4'hE, "R7");
        flags("R7");
        while (sb.size() < D) push(4'(sb.size()));
        both(4'hF, "R7");
        flags("R7");
        while (sb.size() > 0) pull("R7");
        both(4'hD, "R7");
        flags("R7");

        // R10: float the outputs
        chk(dout === 4'hD, "R10 head", int'(dout), 13);
        float_q = 1'b1;
        nclk(1);
        chk(dout !== 4'hD, "R10 float", int'(dout), 16);
        float_q = 1'b0;
        nclk(1);
        chk(dout === 4'hD, "R10 restore", int'(dout), 13);
        pull("R10");

        // R11: chained pair moves every word downstream in order
        for (int i = 0; i < 5; i++) begin
            c_din = 4'(9 + i);
            c_shin = 1'b1;
            nclk(4);
            c_shin = 1'b0;
            nclk(4);
        end
        nclk(80);
        chk(a_or == 1'b0, "R11 upstream empty", int'(a_or), 0);
        chk(b_or == 1'b1, "R11 downstream ready", int'(b_or), 1);
        for (int i = 0; i < 5; i++) begin
            chk(b_q === 4'(9 + i), "R11 order", int'(b_q), 9 + i);
            c_shout = 1'b0;
            nclk(4);
            c_shout = 1'b1;
            nclk(4);
        end
        chk(b_or == 1'b0, "R11 drained", int'(b_or), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule